// File: doc/BRIEF.md
# CAN Bit Destuffer with Stuffing Window

The block sits between a bit sampler and a CAN frame parser. On each raw-bit strobe it decides whether the sampled bit is a genuine frame bit or a stuff bit that the transmitter inserted after five equal bits. Frame bits go to the parser with a strobe, and a running frame-bit count goes with them. Stuff bits are removed from the frame-bit stream. They are still reported on a separate strobe so they can be observed.

The parser sends back the index of the last data bit of the current frame. Stuffing applies only up to a fixed distance past that index. The delimiters, the acknowledge field and the end-of-frame run that follow are therefore never destuffed, even though they hold long recessive runs. The parser holds that input at its all-ones value until the data length is known, which keeps destuffing enabled. A start-of-frame flag sent with a raw bit restarts the history and the count.

Top module: `can_bit_destuffer`

## Requirements
- R1: While reset is high and on the first cycle after it, `fbit_vld` and `stuff_vld` are low and `frame_cnt` is 0.
- R2: A raw bit is a stuff bit when the five raw bits before it in the same frame are all 0 and it is 1, or all 1 and it is 0 (windows 000001 and 111110). A raw bit with fewer than five bits of history in its frame is never a stuff bit. The cycle after the raw strobe, a stuff bit raises `stuff_vld` for one cycle.
- R3: Every raw bit that is not a stuff bit raises `fbit_vld` for one cycle, the cycle after its raw strobe. `bit_val` carries the raw bit value with either strobe.
- R4: A stuff bit remains in the raw history. For example, raw bits 0 0 0 0 0 1 1 1 1 1 0 make both the sixth bit and the eleventh bit stuff bits.
- R5: `frame_cnt` is the number of frame bits accepted since the last start of frame. It updates in the same cycle as `fbit_vld` and stays unchanged on a stuff bit. It saturates at 2^CNT_W-1.
- R6: A raw bit sent with `raw_first` clears the history and the count. That bit is always frame bit 0, so `frame_cnt` becomes 1 and the bit is never a stuff bit. Only this bit is the history for the bits that follow.
- R7: A raw bit that arrives while `frame_cnt` is at least `last_data_bit`+17 is never a stuff bit, whatever the history holds.
- R8: `fbit_vld` and `stuff_vld` are never high together. Neither one is high unless `raw_vld` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_vld | input | 1 | Strobe: one sampled raw bit is present |
| raw_first | input | 1 | With raw_vld: this raw bit is the start-of-frame bit |
| raw_bit | input | 1 | Sampled raw bit value (1 = recessive) |
| last_data_bit | input | CNT_W | Frame-bit index of the last data bit, all ones while unknown |
| fbit_vld | output | 1 | Strobe: a frame bit is delivered |
| stuff_vld | output | 1 | Strobe: a stuff bit was removed |
| bit_val | output | 1 | Value of the classified raw bit |
| frame_cnt | output | CNT_W | Frame bits accepted since start of frame |

## Verification
The assertions assume that `raw_first` is only high together with `raw_vld`. They also assume that `last_data_bit` is the value the parser presents in the same cycle as the raw bit it applies to. The bench raises `raw_first` only on strobe cycles. It changes `last_data_bit` only between frames, or while no raw bit is pending. Idle gaps between raw bits and restarts in the middle of a run are both legal and are part of the stimulus.

// File: rtl/can_dstf_pkg.sv
package can_dstf_pkg;

    // Number of equal raw bits after which the next opposite bit is a stuff bit.
    localparam int RUN_LEN = 5;

    // Distance past the last data bit where stuffing ends.
    localparam int TAIL_BITS = 17;

    typedef enum logic [1:0] {
        BK_NONE  = 2'd0,
        BK_FRAME = 2'd1,
        BK_STUFF = 2'd2
    } bit_kind_e;

    typedef struct packed {
        bit_kind_e kind;
        logic      val;
    } cls_t;

    // True when cur breaks a run of RUN_LEN equal prior bits.
    function automatic logic run_breaks(input logic [RUN_LEN-1:0] prior,
                                        input logic               cur);
        return ((prior == '0) && cur) || ((prior == '1) && !cur);
    endfunction

endpackage

// File: rtl/dstf_hist.sv
module dstf_hist
    import can_dstf_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic           restart,
    input  logic           cur,
    output logic [RUN-1:0] prior,
    output logic           full
);
    localparam int FW = $clog2(RUN + 1);

    logic [RUN-1:0] shr_q;
    logic [FW-1:0]  fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shr_q  <= '0;
            fill_q <= '0;
        end else if (push) begin
            if (restart) begin
                shr_q  <= {{(RUN-1){1'b0}}, cur};
                fill_q <= FW'(1);
            end else begin
                shr_q  <= {shr_q[RUN-2:0], cur};
                if (fill_q != FW'(RUN))
                    fill_q <= fill_q + FW'(1);
            end
        end
    end

    assign prior = shr_q;
    assign full  = (fill_q == FW'(RUN));

endmodule

// File: rtl/dstf_gate.sv
module dstf_gate
    import can_dstf_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             open
);
    localparam int          EW      = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [EW-1:0]    edge_w;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= CNT_W'(1);
        else if (adv && (cnt_q != CNT_MAX))
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign edge_w = {1'b0, limit} + EW'(TAIL_BITS);
    assign open   = ({1'b0, cnt_q} < edge_w);
    assign cnt    = cnt_q;

endmodule

// File: rtl/can_bit_destuffer.sv
module can_bit_destuffer
    import can_dstf_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_vld,
    input  logic             raw_first,
    input  logic             raw_bit,
    input  logic [CNT_W-1:0] last_data_bit,
    output logic             fbit_vld,
    output logic             stuff_vld,
    output logic             bit_val,
    output logic [CNT_W-1:0] frame_cnt
);
    localparam int EW = CNT_W + 1;

    logic [RUN_LEN-1:0] prior;
    logic               hist_full;
    logic               win_open;
    logic               restart;
    logic               is_stuff;
    logic               take_frame;
    cls_t               cls_d, cls_q;

    assign restart    = raw_vld && raw_first;
    assign is_stuff   = raw_vld && !raw_first && hist_full && win_open
                        && run_breaks(prior, raw_bit);
    assign take_frame = raw_vld && !is_stuff;

    dstf_hist #(.RUN(RUN_LEN)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .push    (raw_vld),
        .restart (restart),
        .cur     (raw_bit),
        .prior   (prior),
        .full    (hist_full)
    );

    dstf_gate #(.CNT_W(CNT_W)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .adv     (take_frame),
        .restart (restart),
        .limit   (last_data_bit),
        .cnt     (frame_cnt),
        .open    (win_open)
    );

    always_comb begin
        cls_d.val = raw_bit;
        if (!raw_vld)
            cls_d.kind = BK_NONE;
        else if (is_stuff)
            cls_d.kind = BK_STUFF;
        else
            cls_d.kind = BK_FRAME;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cls_q <= '{kind: BK_NONE, val: 1'b0};
        else
            cls_q <= cls_d;
    end

    assign fbit_vld  = (cls_q.kind == BK_FRAME);
    assign stuff_vld = (cls_q.kind == BK_STUFF);
    assign bit_val   = cls_q.val;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fbit_vld && stuff_vld)); // R8

    AST_NO_SPONT: assert property (@(posedge clk) disable iff (rst)
        (fbit_vld || stuff_vld) |-> $past(raw_vld)); // R8

    AST_FIRST_FRAME: assert property (@(posedge clk) disable iff (rst)
        (raw_vld && raw_first) |=> (fbit_vld && frame_cnt == CNT_W'(1))); // R6

    AST_STUFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        stuff_vld |-> $stable(frame_cnt)); // R5

    AST_STUFF_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (raw_vld && !raw_first
         && ({1'b0, frame_cnt} >= ({1'b0, last_data_bit} + EW'(TAIL_BITS))))
        |=> fbit_vld); // R7

endmodule

// File: tb/sim_can_bit_destuffer.sv
module sim_can_bit_destuffer;
    localparam int CNT_W = 10;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             raw_vld = 1'b0;
    logic             raw_first = 1'b0;
    logic             raw_bit = 1'b0;
    logic [CNT_W-1:0] last_data_bit = '1;
    logic             fbit_vld, stuff_vld, bit_val;
    logic [CNT_W-1:0] frame_cnt;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    int hq[$];
    int m_cnt = 0;
    int m_lim = CMAX;

    always #2 clk = ~clk;

    can_bit_destuffer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .raw_vld(raw_vld), .raw_first(raw_first),
        .raw_bit(raw_bit), .last_data_bit(last_data_bit),
        .fbit_vld(fbit_vld), .stuff_vld(stuff_vld), .bit_val(bit_val),
        .frame_cnt(frame_cnt)
    );

    task automatic check(input bit ok, input string tag, input string got, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %s expected %s", tag, got, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then compare at the next falling edge.
    task automatic step(input bit vld, input bit first, input bit b, input string tag);
        bit stf = 0;
        bit e_f, e_s;
        raw_vld       = vld;
        raw_first     = first;
        raw_bit       = b;
        last_data_bit = CNT_W'(m_lim);
        if (vld) begin
            if (!first && hq.size() == 5 && m_cnt < m_lim + 17) begin
                bit same = 1;
                foreach (hq[i]) if (hq[i] != hq[0]) same = 0;
                stf = same && (int'(b) != hq[4]);
            end
            if (first) begin
                hq.delete();
                hq.push_back(int'(b));
                m_cnt = 1;
            end else begin
                hq.push_back(int'(b));
                if (hq.size() > 5) void'(hq.pop_front());
                if (!stf && m_cnt < CMAX) m_cnt++;
            end
        end
        e_f = vld && !stf;
        e_s = vld && stf;
        @(negedge clk);
        check(fbit_vld == e_f && stuff_vld == e_s && int'(frame_cnt) == m_cnt
              && (!vld || bit_val == b), tag,
              $sformatf("f=%0b s=%0b v=%0b cnt=%0d", fbit_vld, stuff_vld, bit_val, frame_cnt),
              $sformatf("f=%0b s=%0b v=%0b cnt=%0d", e_f, e_s, b, m_cnt));
        raw_vld   = 1'b0;
        raw_first = 1'b0;
    endtask

    task automatic send_bits(input bit first, input string pat, input string tag);
        for (int i = 0; i < pat.len(); i++)
            step(1'b1, first && i == 0, pat[i] == "1", tag);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!fbit_vld && !stuff_vld && frame_cnt == 0, "R1 in reset",
                  $sformatf("f=%0b s=%0b cnt=%0d", fbit_vld, stuff_vld, frame_cnt), "f=0 s=0 cnt=0");
        end
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, "R1 after reset");

        // Bits before any start of frame: short history never stuffs
        send_bits(1'b0, "0000", "R2 short history");

        // Basic stuffing in both polarities, stuff bit kept in history
        m_lim = CMAX;
        send_bits(1'b1, "00000", "R3 frame bits");
        send_bits(1'b0, "1", "R2 stuff after zeros");
        send_bits(1'b0, "11110", "R4 stuff bit in history");
        send_bits(1'b0, "0000111110010", "R2 mixed runs");

        // Idle gaps between raw bits
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 1'b0, (i < 5) ? 1'b1 : 1'b0, "R8 gapped bits");
            step(1'b0, 1'b0, 1'b0, "R8 idle no strobe");
            step(1'b0, 1'b0, 1'b1, "R8 idle no strobe");
        end

        // Restart in the middle of a run clears history and count
        send_bits(1'b0, "11111", "R6 pre-restart run");
        send_bits(1'b1, "0", "R6 first bit never stuff");
        send_bits(1'b0, "00001", "R6 history from first bit");

        // Window: stuffing stops past last_data_bit + 17
        m_lim = 3;
        send_bits(1'b1, "0", "R7 window start");
        for (int i = 0; i < 8; i++)
            send_bits(1'b0, (i % 2) ? "0000000" : "1111111", "R7 window runs");
        m_lim = 0;
        send_bits(1'b1, "01111111111111", "R7 window edge");

        // Run-biased random frames
        for (int f = 0; f < 30; f++) begin
            bit b = 1'b0;
            m_lim = (f % 3 == 0) ? CMAX : int'($urandom_range(0, 80));
            step(1'b1, 1'b1, 1'b0, "R2 random frame start");
            for (int i = 0; i < 150; i++) begin
                if ($urandom_range(0, 3) == 0) b = ~b;
                if ($urandom_range(0, 9) == 0) step(1'b0, 1'b0, 1'b0, "R8 random idle");
                step(1'b1, 1'b0, b, "R3 random bit");
            end
        end

        // Counter saturation with alternating bits
        m_lim = CMAX;
        step(1'b1, 1'b1, 1'b0, "R5 long frame");
        for (int i = 0; i < 1100; i++)
            step(1'b1, 1'b0, (i % 2) ? 1'b0 : 1'b1, "R5 count");
        check(int'(frame_cnt) == CMAX, "R5 saturation",
              $sformatf("%0d", frame_cnt), $sformatf("%0d", CMAX));

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule